// File: doc/BRIEF.md
# Slave-Parallel FPGA Configuration Loader

This block loads a bitstream into a downstream FPGA through an 8-bit slave-parallel port. It runs the whole configuration sequence. First it holds the target in program reset with the mode pins driven. It then waits for the target's initialisation line. Next it clocks each data byte in with one configuration-clock pulse. At the end it applies a fixed run of trailing clocks and checks the done line. The block itself does not interpret the bitstream.

The host supplies the bitstream as packets over a byte stream. Each byte has a valid/ready handshake, and a flag marks the last byte of each packet. A start command begins a run. A packet shorter than the full packet size ends the stream. A finish command closes the stream explicitly. While loading, the block keeps three counters that the host can read: the total number of transferred bytes, an 8-bit wrapping sum of the bytes, and a two-stage code that records what the initialisation line showed. A status query reports whether the target is configured. If it is not, the query also starts a new reset sequence.

Top module: `pcfg_loader`

## Requirements
- R1: After rst_n is released, drive_en_o is 0, s_ready_o is 0, configured_o is 0, and byte_count_o, checksum_o and init_code_o are all 0.
- R2: Once a start is accepted, the block holds prog_n_o=0, cs_n_o=1, cclk_o=1, rdwr_n_o=0 and drive_en_o=1 for exactly RESET_HOLD cycles. During this time mode_o equals the value mode_sel_i had when the start was accepted.
- R3: After the hold, prog_n_o=1 and cs_n_o=0. The block polls init_i once per cycle. init_code_o becomes 200 on the first poll that sees init_i high. If POLL_LIMIT polls all see it low, init_code_o becomes 100. byte_count_o and checksum_o are 0 when polling begins.
- R4: A byte is accepted when s_valid_i and s_ready_o are both high. On the next cycle the byte is on data_o with cclk_o low. On the cycle after that cclk_o is high. s_ready_o is low for both of those cycles.
- R5: Each accepted byte is added to checksum_o modulo 256.
- R6: When the last byte of a packet (s_last_i=1) is accepted, byte_count_o increases by the length of that packet.
- R7: A packet that ends with fewer than PKT_FULL bytes starts the finish sequence after its final clock pulse. A packet of PKT_FULL bytes leaves the block ready for more data.
- R8: Asserting finish_i while the block waits for data starts the finish sequence.
- R9: At the start of the finish sequence, init_code_o increases by 22 if init_i is high and by 11 if it is low.
- R10: The finish sequence issues FLUSH_PULSES clock pulses with cs_n_o=0, then TAIL_PULSES pulses with cs_n_o=1. Each pulse is one cycle high followed by one cycle low.
- R11: After the pulses, drive_en_o falls to 0 and done_i is sampled. configured_o takes that value, and post_cfg_o pulses for one cycle only when done_i was high.
- R12: A query_i in idle gives a one-cycle status_valid_o with status_unconf_o equal to the inverse of configured_o. If the target is unconfigured, the query also restarts the reset hold. If it is configured, the outputs stay released.
- R13: start_i in any state aborts the current activity and enters the reset hold on the next cycle. It also clears configured_o, byte_count_o and checksum_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start command: begin a new configuration run |
| query_i | input | 1 | Status query |
| finish_i | input | 1 | Explicit end-of-stream command |
| mode_sel_i | input | MODE_W | Mode pin value to apply at start |
| s_valid_i | input | 1 | Stream byte valid |
| s_data_i | input | 8 | Stream byte |
| s_last_i | input | 1 | Byte is the last of its packet |
| s_ready_o | output | 1 | Block can take a byte |
| status_valid_o | output | 1 | Query answer strobe |
| status_unconf_o | output | 1 | Query answer: 1 = unconfigured |
| init_i | input | 1 | Target initialisation line |
| done_i | input | 1 | Target done line |
| prog_n_o | output | 1 | Program/reset to target, active low |
| cs_n_o | output | 1 | Chip select, active low |
| rdwr_n_o | output | 1 | Direction: 0 = write |
| cclk_o | output | 1 | Configuration clock |
| drive_en_o | output | 1 | 1 = drive configuration pins, 0 = high impedance |
| mode_o | output | MODE_W | Mode pins |
| data_o | output | 8 | Configuration data bus |
| byte_count_o | output | 32 | Transferred byte count |
| checksum_o | output | 8 | Wrapping byte sum |
| init_code_o | output | 8 | Initialisation status code |
| configured_o | output | 1 | Target reported done |
| post_cfg_o | output | 1 | One-cycle pulse after a successful load |

## Verification
The assertions check the per-cycle rules on every cycle. These are the pin levels during reset hold, the two-cycle ready gap after each accepted byte, the single high cycle of every clock pulse, the checksum step, the restart on start_i, and the shape of the post-configuration pulse. Other behaviours appear only over whole scenarios, so only the bench's scenarios show them. These are the exact hold and poll lengths, the 200/100 and +22/+11 status codes, the per-packet byte totals, the short-packet end of stream, the 64-plus-4 trailing pulse counts, and whether a query restarts the target.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HOLD,
    ST_POLL,
    ST_LOAD,
    ST_SETUP,
    ST_CLKHI,
    ST_FIN,
    ST_FLUSH,
    ST_TAIL,
    ST_CHECK
  } pcfg_state_e;

  localparam logic [7:0] INIT_SEEN   = 8'd200;
  localparam logic [7:0] INIT_MISSED = 8'd100;
  localparam logic [7:0] FIN_HIGH    = 8'd22;
  localparam logic [7:0] FIN_LOW     = 8'd11;

  // wrapping 8-bit byte sum
  function automatic logic [7:0] sum8(input logic [7:0] acc, input logic [7:0] b);
    return acc + b;
  endfunction

  // first stage of the init status code
  function automatic logic [7:0] init_first(input logic init_hi);
    return init_hi ? INIT_SEEN : INIT_MISSED;
  endfunction

  // second stage of the init status code
  function automatic logic [7:0] init_final(input logic [7:0] code, input logic init_hi);
    return code + (init_hi ? FIN_HIGH : FIN_LOW);
  endfunction

endpackage

// File: rtl/pcfg_tally.sv
module pcfg_tally #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             take,
  input  logic             last,
  input  logic [7:0]       byte_in,
  output logic [31:0]      byte_count,
  output logic [7:0]       checksum,
  output logic [LEN_W-1:0] pkt_len
);
  import pcfg_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      byte_count <= '0;
      checksum   <= '0;
      pkt_len    <= '0;
    end else if (take) begin
      checksum <= sum8(checksum, byte_in);
      if (last) begin
        byte_count <= byte_count + 32'(pkt_len) + 32'd1;
        pkt_len    <= '0;
      end else begin
        pkt_len <= pkt_len + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pcfg_clkgen.sv
module pcfg_clkgen #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort,
  input  logic             go,
  input  logic [CNT_W-1:0] n,
  output logic             pulse_hi,
  output logic             last_low
);
  logic [CNT_W-1:0] cnt;
  logic             ph;

  always_ff @(posedge clk) begin
    if (!rst_n || abort) begin
      cnt <= '0;
      ph  <= 1'b0;
    end else if (go) begin
      cnt <= n;
      ph  <= 1'b0;
    end else if (cnt != '0) begin
      if (!ph) begin
        ph <= 1'b1;
      end else begin
        ph  <= 1'b0;
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign pulse_hi = (cnt != '0) && !ph;
  assign last_low = (cnt == CNT_W'(1)) && ph;

endmodule

// File: rtl/pcfg_ctrl.sv
module pcfg_ctrl #(
  parameter int RESET_HOLD   = 16,
  parameter int POLL_LIMIT   = 65535,
  parameter int PKT_FULL     = 64,
  parameter int FLUSH_PULSES = 64,
  parameter int TAIL_PULSES  = 4,
  parameter int MODE_W       = 2,
  parameter int LEN_W        = 16,
  parameter int CNT_W        = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic                   query_i,
  input  logic                   finish_i,
  input  logic [MODE_W-1:0]      mode_sel_i,
  input  logic                   init_i,
  input  logic                   done_i,
  input  logic                   s_valid_i,
  input  logic [7:0]             s_data_i,
  input  logic                   s_last_i,
  input  logic [LEN_W-1:0]       pkt_len_i,
  input  logic                   last_low_i,
  output pcfg_pkg::pcfg_state_e  state_o,
  output logic                   restart_o,
  output logic                   take_o,
  output logic                   clk_go_o,
  output logic [CNT_W-1:0]       clk_n_o,
  output logic                   s_ready_o,
  output logic [7:0]             data_o,
  output logic [MODE_W-1:0]      mode_o,
  output logic [7:0]             init_code_o,
  output logic                   configured_o,
  output logic                   post_cfg_o,
  output logic                   status_valid_o,
  output logic                   status_unconf_o
);
  import pcfg_pkg::*;

  localparam int TMR_MAX = (POLL_LIMIT > RESET_HOLD) ? POLL_LIMIT : RESET_HOLD;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam logic [TMR_W-1:0] HOLD_LAST = TMR_W'(RESET_HOLD - 1);
  localparam logic [TMR_W-1:0] POLL_LAST = TMR_W'(POLL_LIMIT - 1);

  pcfg_state_e      state;
  logic [TMR_W-1:0] tmr;
  logic             fin_pend;
  logic             short_pkt;
  logic             idle_query;

  assign idle_query = (state == ST_IDLE) && query_i;
  assign restart_o  = start_i || (idle_query && !configured_o);
  assign s_ready_o  = (state == ST_LOAD);
  assign take_o     = s_ready_o && s_valid_i && !start_i;
  assign short_pkt  = (int'(pkt_len_i) + 1) < PKT_FULL;
  assign state_o    = state;

  // pulse train launch: flush run from FIN, tail run on the flush run's last low phase
  always_comb begin
    clk_go_o = 1'b0;
    clk_n_o  = CNT_W'(FLUSH_PULSES);
    if (state == ST_FIN) begin
      clk_go_o = 1'b1;
    end else if (state == ST_FLUSH && last_low_i) begin
      clk_go_o = 1'b1;
      clk_n_o  = CNT_W'(TAIL_PULSES);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state           <= ST_IDLE;
      tmr             <= '0;
      fin_pend        <= 1'b0;
      data_o          <= '0;
      mode_o          <= '0;
      init_code_o     <= '0;
      configured_o    <= 1'b0;
      post_cfg_o      <= 1'b0;
      status_valid_o  <= 1'b0;
      status_unconf_o <= 1'b0;
    end else begin
      post_cfg_o     <= 1'b0;
      status_valid_o <= 1'b0;
      if (restart_o) begin
        state        <= ST_HOLD;
        tmr          <= '0;
        fin_pend     <= 1'b0;
        configured_o <= 1'b0;
        mode_o       <= mode_sel_i;
        if (idle_query) begin
          status_valid_o  <= 1'b1;
          status_unconf_o <= !configured_o;
        end
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (query_i) begin
              status_valid_o  <= 1'b1;
              status_unconf_o <= !configured_o;
            end
          end
          ST_HOLD: begin
            if (tmr == HOLD_LAST) begin
              state <= ST_POLL;
              tmr   <= '0;
            end else begin
              tmr <= tmr + 1'b1;
            end
          end
          ST_POLL: begin
            if (init_i || tmr == POLL_LAST) begin
              init_code_o <= init_first(init_i);
              state       <= ST_LOAD;
            end else begin
              tmr <= tmr + 1'b1;
            end
          end
          ST_LOAD: begin
            if (s_valid_i) begin
              data_o   <= s_data_i;
              fin_pend <= s_last_i && short_pkt;
              state    <= ST_SETUP;
            end else if (finish_i) begin
              state <= ST_FIN;
            end
          end
          ST_SETUP: state <= ST_CLKHI;
          ST_CLKHI: state <= fin_pend ? ST_FIN : ST_LOAD;
          ST_FIN: begin
            init_code_o <= init_final(init_code_o, init_i);
            fin_pend    <= 1'b0;
            state       <= ST_FLUSH;
          end
          ST_FLUSH: if (last_low_i) state <= ST_TAIL;
          ST_TAIL:  if (last_low_i) state <= ST_CHECK;
          ST_CHECK: begin
            configured_o <= done_i;
            post_cfg_o   <= done_i;
            state        <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/pcfg_loader.sv
module pcfg_loader #(
  parameter int RESET_HOLD   = 16,
  parameter int POLL_LIMIT   = 65535,
  parameter int PKT_FULL     = 64,
  parameter int FLUSH_PULSES = 64,
  parameter int TAIL_PULSES  = 4,
  parameter int MODE_W       = 2,
  parameter int LEN_W        = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              query_i,
  input  logic              finish_i,
  input  logic [MODE_W-1:0] mode_sel_i,
  input  logic              s_valid_i,
  input  logic [7:0]        s_data_i,
  input  logic              s_last_i,
  output logic              s_ready_o,
  output logic              status_valid_o,
  output logic              status_unconf_o,
  input  logic              init_i,
  input  logic              done_i,
  output logic              prog_n_o,
  output logic              cs_n_o,
  output logic              rdwr_n_o,
  output logic              cclk_o,
  output logic              drive_en_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [7:0]        data_o,
  output logic [31:0]       byte_count_o,
  output logic [7:0]        checksum_o,
  output logic [7:0]        init_code_o,
  output logic              configured_o,
  output logic              post_cfg_o
);
  import pcfg_pkg::*;

  localparam int PULSE_MAX = (FLUSH_PULSES > TAIL_PULSES) ? FLUSH_PULSES : TAIL_PULSES;
  localparam int CNT_W     = $clog2(PULSE_MAX + 1);

  pcfg_state_e      state;
  logic             restart;
  logic             take;
  logic             clk_go;
  logic [CNT_W-1:0] clk_n;
  logic             pulse_hi;
  logic             last_low;
  logic [LEN_W-1:0] pkt_len;

  pcfg_ctrl #(
    .RESET_HOLD  (RESET_HOLD),
    .POLL_LIMIT  (POLL_LIMIT),
    .PKT_FULL    (PKT_FULL),
    .FLUSH_PULSES(FLUSH_PULSES),
    .TAIL_PULSES (TAIL_PULSES),
    .MODE_W      (MODE_W),
    .LEN_W       (LEN_W),
    .CNT_W       (CNT_W)
  ) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .query_i        (query_i),
    .finish_i       (finish_i),
    .mode_sel_i     (mode_sel_i),
    .init_i         (init_i),
    .done_i         (done_i),
    .s_valid_i      (s_valid_i),
    .s_data_i       (s_data_i),
    .s_last_i       (s_last_i),
    .pkt_len_i      (pkt_len),
    .last_low_i     (last_low),
    .state_o        (state),
    .restart_o      (restart),
    .take_o         (take),
    .clk_go_o       (clk_go),
    .clk_n_o        (clk_n),
    .s_ready_o      (s_ready_o),
    .data_o         (data_o),
    .mode_o         (mode_o),
    .init_code_o    (init_code_o),
    .configured_o   (configured_o),
    .post_cfg_o     (post_cfg_o),
    .status_valid_o (status_valid_o),
    .status_unconf_o(status_unconf_o)
  );

  pcfg_tally #(.LEN_W(LEN_W)) u_tally (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (restart),
    .take      (take),
    .last      (s_last_i),
    .byte_in   (s_data_i),
    .byte_count(byte_count_o),
    .checksum  (checksum_o),
    .pkt_len   (pkt_len)
  );

  pcfg_clkgen #(.CNT_W(CNT_W)) u_clkgen (
    .clk     (clk),
    .rst_n   (rst_n),
    .abort   (restart),
    .go      (clk_go),
    .n       (clk_n),
    .pulse_hi(pulse_hi),
    .last_low(last_low)
  );

  // pin levels decoded from the controller state
  always_comb begin
    prog_n_o   = 1'b1;
    cs_n_o     = 1'b1;
    cclk_o     = 1'b0;
    drive_en_o = 1'b1;
    unique case (state)
      ST_HOLD: begin
        prog_n_o = 1'b0;
        cclk_o   = 1'b1;
      end
      ST_POLL, ST_LOAD, ST_SETUP, ST_FIN: cs_n_o = 1'b0;
      ST_CLKHI: begin
        cs_n_o = 1'b0;
        cclk_o = 1'b1;
      end
      ST_FLUSH: begin
        cs_n_o = 1'b0;
        cclk_o = pulse_hi;
      end
      ST_TAIL: cclk_o = pulse_hi;
      default: drive_en_o = 1'b0;
    endcase
  end

  assign rdwr_n_o = !drive_en_o;

endmodule

// File: rtl/pcfg_loader_chk.sv
module pcfg_loader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        s_valid_i,
  input logic [7:0]  s_data_i,
  input logic        s_ready_o,
  input logic        status_valid_o,
  input logic        status_unconf_o,
  input logic        prog_n_o,
  input logic        cs_n_o,
  input logic        rdwr_n_o,
  input logic        cclk_o,
  input logic        drive_en_o,
  input logic [31:0] byte_count_o,
  input logic [7:0]  checksum_o,
  input logic        configured_o,
  input logic        post_cfg_o
);

  AST_HOLD_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n_o |-> (cs_n_o && cclk_o && drive_en_o && !rdwr_n_o)); // R2

  AST_READY_CONTEXT: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready_o |-> (!cs_n_o && prog_n_o && drive_en_o && !cclk_o)); // R4

  AST_READY_GAP_A: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid_i && s_ready_o && !start_i) |=> !s_ready_o); // R4

  AST_READY_GAP_B: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid_i && s_ready_o && !start_i) |=> ##1 !s_ready_o); // R4

  AST_CCLK_ONE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (cclk_o && prog_n_o && !start_i) |=> !cclk_o); // R10

  AST_CKSUM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid_i && s_ready_o && !start_i) |=>
      (checksum_o == 8'($past(checksum_o) + $past(s_data_i)))); // R5

  AST_POST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    post_cfg_o |=> !post_cfg_o); // R11

  AST_POST_CONTEXT: assert property (@(posedge clk) disable iff (!rst_n)
    post_cfg_o |-> (configured_o && !drive_en_o)); // R11

  AST_START_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!prog_n_o && byte_count_o == 32'd0 && checksum_o == 8'd0 && !configured_o)); // R13

  AST_QUERY_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    status_valid_o |-> (status_unconf_o == !configured_o)); // R12

endmodule

bind pcfg_loader pcfg_loader_chk u_chk (.*);

// File: tb/pcfg_loader_tb.sv
module pcfg_loader_tb;

  localparam int HOLD_C = 8;
  localparam int POLL_C = 40;
  localparam int FULL_C = 64;

  // [23:20] full packets, [19:12] short length, [11:4] seed, [3:2] mode, [1] init at finish, [0] done
  localparam logic [23:0] VECS [4] = '{24'h005107, 24'h103F0B, 24'h23FA5C, 24'h001FF2};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 0, query_i = 0, finish_i = 0;
  logic [1:0] mode_sel_i = 0;
  logic s_valid_i = 0, s_last_i = 0;
  logic [7:0] s_data_i = 0;
  logic init_i = 1, done_i = 0;
  logic s_ready_o, status_valid_o, status_unconf_o;
  logic prog_n_o, cs_n_o, rdwr_n_o, cclk_o, drive_en_o;
  logic [1:0] mode_o;
  logic [7:0] data_o, checksum_o, init_code_o;
  logic [31:0] byte_count_o;
  logic configured_o, post_cfg_o;

  int total = 0;
  int bad = 0;
  int rises = 0, hi_rises = 0, posts = 0;
  logic prev_cclk = 1'b0;

  always #2 clk = ~clk;

  pcfg_loader #(.RESET_HOLD(HOLD_C), .POLL_LIMIT(POLL_C)) u_dut (.*);

  always @(negedge clk) begin
    if (cclk_o && !prev_cclk) begin
      rises++;
      if (cs_n_o) hi_rises++;
    end
    prev_cclk = cclk_o;
    if (post_cfg_o) posts++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input logic lst);
    while (!s_ready_o) @(negedge clk);
    s_valid_i = 1'b1; s_data_i = b; s_last_i = lst;
    @(negedge clk);
    s_valid_i = 1'b0; s_last_i = 1'b0;
  endtask

  task automatic pulse_start(input logic [1:0] m);
    mode_sel_i = m; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_release();
    while (drive_en_o) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog req=all act=timeout exp=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 drive_en", drive_en_o, 0);
    chk("R1 ready", s_ready_o, 0);
    chk("R1 configured", configured_o, 0);
    chk("R1 counts", {byte_count_o[23:0], checksum_o}, 0);
    chk("R1 init_code", init_code_o, 0);

    // table-driven full runs
    for (int v = 0; v < 4; v++) begin
      int nfull, slen, nbytes, hold_n, r0, h0, p0, k;
      logic [7:0] seed, sum, b;
      logic iv, dv;
      logic [1:0] md;
      nfull = int'(VECS[v][23:20]);
      slen  = int'(VECS[v][19:12]);
      seed  = VECS[v][11:4];
      md    = VECS[v][3:2];
      iv    = VECS[v][1];
      dv    = VECS[v][0];
      nbytes = nfull * FULL_C + slen;
      init_i = 1'b1; done_i = dv;
      pulse_start(md);
      hold_n = 0;
      while (!prog_n_o) begin
        if (hold_n == 0) begin
          chk("R2 hold pins", {cs_n_o, cclk_o, rdwr_n_o, drive_en_o}, 4'b1101);
          chk("R2 mode", mode_o, md);
        end
        hold_n++;
        @(negedge clk);
      end
      chk("R2 hold length", hold_n, HOLD_C);
      chk("R3 cleared", {byte_count_o[23:0], checksum_o}, 0);
      r0 = rises; h0 = hi_rises; p0 = posts;
      sum = 8'd0; k = 0;
      for (int p = 0; p <= nfull; p++) begin
        int plen;
        plen = (p == nfull) ? slen : FULL_C;
        for (int i = 0; i < plen; i++) begin
          b = seed + 8'(k * 37);
          sum = sum + b;
          k++;
          if (p == nfull && i == plen - 1) init_i = iv;
          send_byte(b, i == plen - 1);
        end
      end
      wait_release();
      chk("R6 byte_count", byte_count_o, nbytes);
      chk("R5 checksum", checksum_o, sum);
      chk("R9 init_code", init_code_o, 8'd200 + (iv ? 8'd22 : 8'd11));
      chk("R10 total pulses", rises - r0, nbytes + 68);
      chk("R10 tail pulses", hi_rises - h0, 4);
      chk("R11 configured", configured_o, dv);
      chk("R11 post pulses", posts - p0, dv ? 1 : 0);
      chk("R7 short ends", drive_en_o, 0);
    end

    // poll timeout, byte timing, full packet, explicit finish
    begin
      int cnt, r0, h0;
      init_i = 1'b0; done_i = 1'b0;
      pulse_start(2'd1);
      while (!prog_n_o) @(negedge clk);
      cnt = 0;
      while (!s_ready_o) begin cnt++; @(negedge clk); end
      chk("R3 poll length", cnt, POLL_C);
      chk("R3 init timeout", init_code_o, 100);
      s_valid_i = 1'b1; s_data_i = 8'h5A; s_last_i = 1'b0;
      @(negedge clk);
      s_valid_i = 1'b0;
      chk("R4 setup", {data_o, cclk_o, s_ready_o}, {8'h5A, 2'b00});
      @(negedge clk);
      chk("R4 clock high", {cclk_o, s_ready_o}, 2'b10);
      @(negedge clk);
      chk("R4 ready again", {cclk_o, s_ready_o}, 2'b01);
      for (int i = 1; i < FULL_C; i++) send_byte(8'(i), i == FULL_C - 1);
      repeat (4) @(negedge clk);
      chk("R7 full packet keeps loading", {drive_en_o, s_ready_o, cs_n_o}, 3'b110);
      chk("R6 full packet count", byte_count_o, FULL_C);
      init_i = 1'b1;
      r0 = rises; h0 = hi_rises;
      finish_i = 1'b1;
      @(negedge clk);
      finish_i = 1'b0;
      wait_release();
      chk("R8 finish init_code", init_code_o, 122);
      chk("R8 finish pulses", rises - r0, 68);
      chk("R10 finish tail", hi_rises - h0, 4);
      chk("R11 not configured", configured_o, 0);
    end

    // query while unconfigured restarts; query while configured does not
    query_i = 1'b1;
    @(negedge clk);
    query_i = 1'b0;
    chk("R12 unconf answer", {status_valid_o, status_unconf_o, prog_n_o}, 3'b110);
    done_i = 1'b1;
    while (!s_ready_o) @(negedge clk);
    finish_i = 1'b1;
    @(negedge clk);
    finish_i = 1'b0;
    wait_release();
    chk("R11 configured empty stream", configured_o, 1);
    chk("R9 init 222", init_code_o, 222);
    query_i = 1'b1;
    @(negedge clk);
    query_i = 1'b0;
    chk("R12 conf answer", {status_valid_o, status_unconf_o}, 2'b10);
    repeat (3) @(negedge clk);
    chk("R12 stays released", {drive_en_o, prog_n_o}, 2'b01);

    // start in the middle of loading
    pulse_start(2'd2);
    while (!s_ready_o) @(negedge clk);
    send_byte(8'h11, 1'b0);
    send_byte(8'h22, 1'b0);
    send_byte(8'h33, 1'b0);
    @(negedge clk);
    chk("R5 partial sum", checksum_o, 8'h66);
    pulse_start(2'd3);
    chk("R13 abort", {prog_n_o, checksum_o, configured_o, mode_o}, {1'b0, 8'h00, 1'b0, 2'd3});
    chk("R13 count cleared", byte_count_o, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule